// File: doc/BRIEF.md
# Root Hub Port Status and Control Register

This block keeps the status and control state for one downstream port of a USB 2.0 host controller root hub. Software reads and writes it through a simple single-cycle register interface with byte strobes. Hardware changes the same fields from event inputs on the port side: a J-to-K line event while the port is suspended, the overcurrent sense level, an error-driven disable at the end-of-frame check point, and an acknowledgement that the port has settled back into high-speed idle.

From that state the block drives three outputs. One requests full-speed K resume signalling on the line. One holds the port disabled. One is a single-cycle request that tells the global status logic to latch its port-change-detect flag. Resume timing, line-state decoding and the frame scheduler sit outside the block and reach it only as strobes and levels.

The fields sit in byte 0 of the data word: bit 0 port enabled (read/write), bit 1 enable-change (write 1 to clear), bit 2 overcurrent active (read-only), bit 3 overcurrent change (write 1 to clear), bit 4 force resume (read/write). All other bits read as 0 and ignore writes.

Top module: `hport_status_reg`

## Requirements
- R1: After reset, all fields of rd_data read 0, drive_resume_k_o and pcd_pulse_o are 0, and port_disable_o is 1.
- R2: A software write of 1 to bit 4 sets it and starts K signalling on the next cycle, and pcd_pulse_o stays 0, even when a J-to-K event arrives in the same cycle.
- R3: A jk_det_i strobe while suspended_i is 1 and bit 4 is 0 sets bit 4, starts K signalling and raises pcd_pulse_o for exactly one cycle. With suspended_i at 0 the strobe changes nothing.
- R4: A software write of 0 to bit 4 while it is 1 stops K signalling on the next cycle. Bit 4 keeps reading 1 until an hs_idle_ack_i strobe, then reads 0. An acknowledgement with no exit pending has no effect.
- R5: Bit 2 follows oc_in_i one cycle later, and software writes to it have no effect.
- R6: Bit 3 is set on every change of bit 2, in both directions. Writing 1 clears it, and writing 0 leaves it unchanged.
- R7: One cycle after bit 2 reads 1, bit 0 is cleared and port_disable_o is 1. While bit 2 is 1, software writes of 1 to bit 0 are ignored. After bit 2 returns to 0, software can set bit 0 again.
- R8: An eof2_err_i strobe while bit 0 is 1 clears bit 0 and sets bit 1. A software disable, an overcurrent disable, or an error strobe while the port is already disabled leaves bit 1 at 0. Writing 1 to bit 1 clears it.
- R9: When a hardware event that sets bit 1 or bit 3 falls in the same cycle as a software write of 1 to clear that bit, the bit ends up set. An error disable also takes priority over a software enable written in the same cycle.
- R10: A write with wr_strb_i[0] at 0 changes no field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write enable |
| wr_data_i | input | DATA_W | Write data |
| wr_strb_i | input | DATA_W/8 | Byte write strobes |
| rd_data_o | output | DATA_W | Register read value |
| suspended_i | input | 1 | Port is in the suspend state |
| jk_det_i | input | 1 | Strobe: J-to-K transition seen on the line |
| oc_in_i | input | 1 | Overcurrent sense level |
| eof2_err_i | input | 1 | Strobe: port error found at the end-of-frame check point |
| hs_idle_ack_i | input | 1 | Strobe: port has reached high-speed idle |
| drive_resume_k_o | output | 1 | Request to drive K resume signalling |
| port_disable_o | output | 1 | Port held disabled |
| pcd_pulse_o | output | 1 | One-cycle port-change-detect request |

## Verification
The bench builds the block with a 32-bit data word and automatic overcurrent disable turned on, which is the setting where an overcurrent level has to fight a software enable, and where the R7 ordering becomes visible at the ports. A 4-bit strobe bus also leaves room for writes where only upper byte lanes are active, so the bench can show that these reach no field. Same-cycle collisions between hardware events and software writes are driven on purpose to expose which source has priority.

// File: rtl/hport_pkg.sv
package hport_pkg;
   localparam int unsigned F_EN     = 0;
   localparam int unsigned F_ENCHG  = 1;
   localparam int unsigned F_OCACT  = 2;
   localparam int unsigned F_OCCHG  = 3;
   localparam int unsigned F_RESUME = 4;
   localparam int unsigned FIELD_SPAN = 5;
   localparam int unsigned LANE_W = 8;

   typedef struct packed {
      logic resume;
      logic oc_chg;
      logic oc_act;
      logic en_chg;
      logic en;
   } hport_fields_t;
endpackage

// File: rtl/hport_resume_ctl.sv
module hport_resume_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic sw_wr,
   input  logic sw_val,
   input  logic suspended,
   input  logic jk_det,
   input  logic hs_ack,
   output logic resume_bit,
   output logic drive_k,
   output logic pcd_pulse
);
   logic rs_q, exit_q, pcd_q;
   logic sw_set, hw_set, sw_clr;

   assign sw_set = sw_wr & sw_val;
   assign hw_set = jk_det & suspended & ~rs_q & ~sw_set;
   assign sw_clr = sw_wr & ~sw_val & rs_q & ~exit_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rs_q   <= 1'b0;
         exit_q <= 1'b0;
         pcd_q  <= 1'b0;
      end else begin
         pcd_q <= hw_set;
         if (sw_set || hw_set) begin
            rs_q   <= 1'b1;
            exit_q <= 1'b0;
         end else if (sw_clr) begin
            exit_q <= 1'b1;
         end else if (exit_q && hs_ack) begin
            rs_q   <= 1'b0;
            exit_q <= 1'b0;
         end
      end
   end

   assign resume_bit = rs_q;
   assign drive_k    = rs_q & ~exit_q;
   assign pcd_pulse  = pcd_q;

   // R3: a change-detect request only follows a J-to-K event seen while suspended
   a_r3_pcd_cause: assert property (@(posedge clk) disable iff (!rst_n)
      pcd_pulse |-> $past(jk_det && suspended));
   // R3: the request lasts one cycle
   a_r3_pcd_single: assert property (@(posedge clk) disable iff (!rst_n)
      pcd_pulse |=> !pcd_pulse);
   // R2: software-started resume never raises the request
   a_r2_no_pcd_sw: assert property (@(posedge clk) disable iff (!rst_n)
      sw_set |=> !pcd_pulse);
   // R4: K stops at once when software asks to leave resume
   a_r4_k_off: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_wr && !sw_val && resume_bit) |=> !drive_k);
   // R4: the bit keeps reading 1 until the idle acknowledgement
   a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (resume_bit && !drive_k && !hs_ack) |=> resume_bit);
endmodule

// File: rtl/hport_oc_track.sv
module hport_oc_track (
   input  logic clk,
   input  logic rst_n,
   input  logic oc_in,
   input  logic chg_clr,
   output logic oc_active,
   output logic oc_change
);
   logic oca_q, occ_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         oca_q <= 1'b0;
         occ_q <= 1'b0;
      end else begin
         oca_q <= oc_in;
         if (oc_in != oca_q) occ_q <= 1'b1;
         else if (chg_clr)   occ_q <= 1'b0;
      end
   end

   assign oc_active = oca_q;
   assign oc_change = occ_q;

   // R5: the active bit tracks the sense input with one cycle of lag
   a_r5_follow: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (oc_active == $past(oc_in)));
   // R6: every change of the active bit leaves the change flag set
   a_r6_flag_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
      (oc_active != $past(oc_active)) |-> oc_change);
endmodule

// File: rtl/hport_enable_ctl.sv
module hport_enable_ctl #(
   parameter bit OC_AUTO_DISABLE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sw_wr,
   input  logic sw_en_val,
   input  logic chg_clr,
   input  logic eof2_err,
   input  logic oc_active,
   output logic port_en,
   output logic en_change
);
   logic en_q, chg_q, oc_block, err_off;

   generate
      if (OC_AUTO_DISABLE) begin : g_oc_gate
         assign oc_block = oc_active;
         // R7: an overcurrent reading forces the port off on the next cycle
         a_r7_oc_off: assert property (@(posedge clk) disable iff (!rst_n)
            oc_active |=> !port_en);
      end else begin : g_oc_free
         assign oc_block = 1'b0;
      end
   endgenerate

   assign err_off = eof2_err & en_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         chg_q <= 1'b0;
      end else begin
         if (err_off)       en_q <= 1'b0;
         else if (oc_block) en_q <= 1'b0;
         else if (sw_wr)    en_q <= sw_en_val;

         if (err_off)      chg_q <= 1'b1;
         else if (chg_clr) chg_q <= 1'b0;
      end
   end

   assign port_en   = en_q;
   assign en_change = chg_q;

   // R8: the change flag only rises after an error strobe on an enabled port
   a_r8_chg_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en_change) |-> $past(eof2_err && port_en));
   // R8: the error strobe on an enabled port takes the port down
   a_r8_err_off: assert property (@(posedge clk) disable iff (!rst_n)
      (eof2_err && port_en) |=> (!port_en && en_change));
endmodule

// File: rtl/hport_status_reg.sv
module hport_status_reg #(
   parameter int unsigned DATA_W          = 32,
   parameter bit          OC_AUTO_DISABLE = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en_i,
   input  logic [DATA_W-1:0]     wr_data_i,
   input  logic [DATA_W/8-1:0]   wr_strb_i,
   output logic [DATA_W-1:0]     rd_data_o,
   input  logic                  suspended_i,
   input  logic                  jk_det_i,
   input  logic                  oc_in_i,
   input  logic                  eof2_err_i,
   input  logic                  hs_idle_ack_i,
   output logic                  drive_resume_k_o,
   output logic                  port_disable_o,
   output logic                  pcd_pulse_o
);
   import hport_pkg::*;

   localparam int unsigned STRB_W = DATA_W / LANE_W;
   localparam int unsigned PAD_W  = DATA_W - LANE_W;

   initial begin
      a_cfg_width: assert (DATA_W >= LANE_W && (DATA_W % LANE_W) == 0)
         else $error("DATA_W must be a nonzero multiple of %0d", LANE_W);
      a_cfg_span: assert (FIELD_SPAN <= LANE_W)
         else $error("fields do not fit in one byte lane");
   end

   logic               lane0_wr;
   logic [LANE_W-1:0]  lane0_d;
   logic [LANE_W-1:0]  lane0_rd;
   hport_fields_t      fld;

   assign lane0_wr = wr_en_i & wr_strb_i[0];
   assign lane0_d  = wr_data_i[LANE_W-1:0];

   hport_resume_ctl u_resume (
      .clk        (clk),
      .rst_n      (rst_n),
      .sw_wr      (lane0_wr),
      .sw_val     (lane0_d[F_RESUME]),
      .suspended  (suspended_i),
      .jk_det     (jk_det_i),
      .hs_ack     (hs_idle_ack_i),
      .resume_bit (fld.resume),
      .drive_k    (drive_resume_k_o),
      .pcd_pulse  (pcd_pulse_o)
   );

   hport_oc_track u_oc (
      .clk       (clk),
      .rst_n     (rst_n),
      .oc_in     (oc_in_i),
      .chg_clr   (lane0_wr & lane0_d[F_OCCHG]),
      .oc_active (fld.oc_act),
      .oc_change (fld.oc_chg)
   );

   hport_enable_ctl #(
      .OC_AUTO_DISABLE (OC_AUTO_DISABLE)
   ) u_enable (
      .clk       (clk),
      .rst_n     (rst_n),
      .sw_wr     (lane0_wr),
      .sw_en_val (lane0_d[F_EN]),
      .chg_clr   (lane0_wr & lane0_d[F_ENCHG]),
      .eof2_err  (eof2_err_i),
      .oc_active (fld.oc_act),
      .port_en   (fld.en),
      .en_change (fld.en_chg)
   );

   always_comb begin
      lane0_rd = '0;
      lane0_rd[F_EN]     = fld.en;
      lane0_rd[F_ENCHG]  = fld.en_chg;
      lane0_rd[F_OCACT]  = fld.oc_act;
      lane0_rd[F_OCCHG]  = fld.oc_chg;
      lane0_rd[F_RESUME] = fld.resume;
   end

   generate
      if (STRB_W > 1) begin : g_wide
         assign rd_data_o = {{PAD_W{1'b0}}, lane0_rd};
      end else begin : g_narrow
         assign rd_data_o = lane0_rd;
      end
   endgenerate

   assign port_disable_o = ~fld.en;

   // R10: a write whose lane-0 strobe is low cannot clear the overcurrent flag
   a_r10_lane_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && !wr_strb_i[0] && fld.oc_chg) |=> fld.oc_chg);
   // R1: disable output mirrors the enable field at all times
   a_r1_disable_pin: assert property (@(posedge clk) disable iff (!rst_n)
      port_disable_o == !rd_data_o[F_EN]);
endmodule

// File: tb/hport_status_reg_bench.sv
module hport_status_reg_bench;
   localparam int unsigned DW = 32;
   localparam int unsigned SW = DW / 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic [SW-1:0] wr_strb = '0;
   logic [DW-1:0] rd_data;
   logic suspended = 1'b0, jk_det = 1'b0, oc_in = 1'b0, eof2_err = 1'b0, hs_ack = 1'b0;
   logic drive_k, port_dis, pcd;

   int checks = 0;
   int failures = 0;
   int cycles = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   hport_status_reg #(.DATA_W(DW), .OC_AUTO_DISABLE(1'b1)) u_hport_status_reg (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data), .wr_strb_i(wr_strb),
      .rd_data_o(rd_data), .suspended_i(suspended), .jk_det_i(jk_det), .oc_in_i(oc_in),
      .eof2_err_i(eof2_err), .hs_idle_ack_i(hs_ack), .drive_resume_k_o(drive_k),
      .port_disable_o(port_dis), .pcd_pulse_o(pcd)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic reg_wr(input logic [7:0] d, input logic [SW-1:0] s);
      @(negedge clk);
      wr_en = 1'b1; wr_data = {{(DW-8){1'b0}}, d}; wr_strb = s;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0; wr_strb = '0;
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000 && !done) begin
         done = 1'b1;
         failures++;
         $display("FAIL watchdog actual=%0d expected=<20000 cycles", cycles);
         summary();
      end
   end

   task automatic t_reset();
      chk("R1 rd_data", rd_data, 32'h0);
      chk("R1 drive_k", {31'b0, drive_k}, 32'h0);
      chk("R1 port_disable", {31'b0, port_dis}, 32'h1);
      chk("R1 pcd", {31'b0, pcd}, 32'h0);
   endtask

   task automatic t_sw_resume();
      reg_wr(8'h10, 4'h1);
      chk("R2 bit4 set", {31'b0, rd_data[4]}, 32'h1);
      chk("R2 K driven", {31'b0, drive_k}, 32'h1);
      chk("R2 no pcd", {31'b0, pcd}, 32'h0);
      reg_wr(8'h00, 4'h1);
      chk("R4 K stops", {31'b0, drive_k}, 32'h0);
      chk("R4 bit4 held", {31'b0, rd_data[4]}, 32'h1);
      repeat (3) @(negedge clk);
      chk("R4 bit4 still held", {31'b0, rd_data[4]}, 32'h1);
      hs_ack = 1'b1; @(negedge clk); hs_ack = 1'b0;
      chk("R4 bit4 cleared on ack", {31'b0, rd_data[4]}, 32'h0);
      hs_ack = 1'b1; @(negedge clk); hs_ack = 1'b0;
      chk("R4 stray ack", {31'b0, rd_data[4]}, 32'h0);
   endtask

   task automatic t_jk();
      jk_det = 1'b1; @(negedge clk); jk_det = 1'b0;
      chk("R3 jk not suspended bit4", {31'b0, rd_data[4]}, 32'h0);
      chk("R3 jk not suspended pcd", {31'b0, pcd}, 32'h0);
      suspended = 1'b1;
      @(negedge clk);
      jk_det = 1'b1; @(negedge clk); jk_det = 1'b0;
      chk("R3 pcd pulse", {31'b0, pcd}, 32'h1);
      chk("R3 bit4 set", {31'b0, rd_data[4]}, 32'h1);
      chk("R3 K driven", {31'b0, drive_k}, 32'h1);
      @(negedge clk);
      chk("R3 pcd one cycle", {31'b0, pcd}, 32'h0);
      reg_wr(8'h00, 4'h1);
      hs_ack = 1'b1; @(negedge clk); hs_ack = 1'b0;
      chk("R4 exit after jk", {31'b0, rd_data[4]}, 32'h0);
      jk_det = 1'b1; wr_en = 1'b1; wr_data = 32'h10; wr_strb = 4'h1;
      @(negedge clk);
      jk_det = 1'b0; wr_en = 1'b0; wr_data = '0; wr_strb = '0;
      chk("R2 collision no pcd", {31'b0, pcd}, 32'h0);
      chk("R2 collision bit4", {31'b0, rd_data[4]}, 32'h1);
      reg_wr(8'h00, 4'h1);
      hs_ack = 1'b1; @(negedge clk); hs_ack = 1'b0;
      suspended = 1'b0;
   endtask

   task automatic t_oc();
      reg_wr(8'h01, 4'h1);
      chk("R7 enable", {28'b0, rd_data[3:0]}, 32'h1);
      chk("R7 port on", {31'b0, port_dis}, 32'h0);
      oc_in = 1'b1;
      @(negedge clk);
      chk("R5 active lag", {31'b0, rd_data[2]}, 32'h1);
      @(negedge clk);
      chk("R7 oc disable", {28'b0, rd_data[3:0]}, 32'hC);
      chk("R7 port_disable", {31'b0, port_dis}, 32'h1);
      reg_wr(8'h01, 4'h1);
      chk("R7 enable ignored", {31'b0, rd_data[0]}, 32'h0);
      reg_wr(8'h04, 4'h1);
      chk("R5 read-only", {31'b0, rd_data[2]}, 32'h1);
      reg_wr(8'h00, 4'h1);
      chk("R6 write 0 no effect", {31'b0, rd_data[3]}, 32'h1);
      reg_wr(8'h08, 4'hE);
      chk("R10 lane0 strobe low", {31'b0, rd_data[3]}, 32'h1);
      reg_wr(8'h08, 4'h1);
      chk("R6 w1c", {28'b0, rd_data[3:0]}, 32'h4);
      oc_in = 1'b0; wr_en = 1'b1; wr_data = 32'h08; wr_strb = 4'h1;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0; wr_strb = '0;
      chk("R9 oc set wins", {28'b0, rd_data[3:0]}, 32'h8);
      reg_wr(8'h08, 4'h1);
      reg_wr(8'h01, 4'h1);
      chk("R7 re-enable", {28'b0, rd_data[3:0]}, 32'h1);
   endtask

   task automatic t_eof2();
      reg_wr(8'h00, 4'h1);
      chk("R8 sw disable no flag", {30'b0, rd_data[1:0]}, 32'h0);
      reg_wr(8'h01, 4'h1);
      eof2_err = 1'b1; @(negedge clk); eof2_err = 1'b0;
      chk("R8 error disable", {30'b0, rd_data[1:0]}, 32'h2);
      chk("R8 port_disable", {31'b0, port_dis}, 32'h1);
      reg_wr(8'h02, 4'h1);
      chk("R8 w1c", {30'b0, rd_data[1:0]}, 32'h0);
      eof2_err = 1'b1; @(negedge clk); eof2_err = 1'b0;
      chk("R8 error while disabled", {30'b0, rd_data[1:0]}, 32'h0);
      reg_wr(8'h01, 4'h1);
      eof2_err = 1'b1; wr_en = 1'b1; wr_data = 32'h03; wr_strb = 4'h1;
      @(negedge clk);
      eof2_err = 1'b0; wr_en = 1'b0; wr_data = '0; wr_strb = '0;
      chk("R9 error beats write", {30'b0, rd_data[1:0]}, 32'h2);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_sw_resume();
      t_jk();
      t_oc();
      t_eof2();
      done = 1'b1;
      summary();
   end
endmodule